// File: doc/BRIEF.md
# Core-side cache invalidation decoder

This block sits inside one core of an eight-core cluster. It receives invalidation packets from the shared second-level cache and clears the matching valid bits of the core's two first-level caches. One second-level line (64 bytes) spans four 16-byte data-cache lines and two 32-byte instruction-cache lines. For that reason a packet carries four groups of per-core fields, one group for each 16-byte quarter of the evicted line. Groups for the even quarters use 4-bit codes that can name either cache. Groups for the odd quarters use 3-bit codes that name only the data cache. The block selects the fields that belong to its own core number, builds each set index from the packet address, and applies all of them in one update.

Both valid arrays are held in registers: 128 sets by 4 ways for the data cache and 128 sets by 4 ways for the instruction cache. A packet is taken when `pkt_valid` and `pkt_ready` are both high. `pkt_ready` then stays low for one cycle while the update is written. A test write port sets or clears single valid bits, and a combinational read port shows all ways of one set in both caches.

Top module: `inv_vec_decoder`

## Requirements
- R1: After reset every valid bit of both arrays is 1 and `pkt_ready` is 1.
- R2: A packet is accepted on a rising edge where `pkt_valid` and `pkt_ready` are both 1. `pkt_ready` is 0 for exactly the next cycle. The valid bits change on the following edge and are visible on the read port from then on.
- R3: The packet address field is PA[11:6] = pkt_data[117:112]. For quarter q (0..3), the data-cache set is {pkt_data[116:112], q[1:0]}. For half h (0..1), the instruction-cache set is {pkt_data[117:112], h}.
- R4: Quarters 0 and 2 use 4-bit fields at pkt_data[4*C+3:4*C] and pkt_data[56+4*C+3:56+4*C], where C is the core number parameter. Code bits [1:0]=00 do nothing. Bit 0 = 1 clears data-cache way code[3:2] in quarter q's set. Bits [1:0]=10 clear instruction-cache way code[3:2] in half q/2.
- R5: Quarters 1 and 3 use 3-bit fields at pkt_data[32+3*C+2:32+3*C] and pkt_data[88+3*C+2:88+3*C]. Bit 0 = 0 does nothing. Bit 0 = 1 clears data-cache way code[2:1] in that quarter's set.
- R6: When pkt_data[120:118] equals C, bit 123 clears all four data-cache ways at set {pkt_data[116:112], pkt_data[122:121]}. Under the same condition, bit 124 clears all four instruction-cache ways at set {pkt_data[117:112], pkt_data[122]}.
- R7: When pkt_data[120:118] differs from C, bits 123 and 124 have no effect.
- R8: Fields that belong to other core numbers have no effect.
- R9: The fields of all four quarters and both clear-all bits take effect in the same update.
- R10: When `tw_en` is 1, the edge writes `tw_val` into way `tw_way` of set `tw_set`: in the instruction array when `tw_icache` = 1, in the data array otherwise. If that same edge also clears the bit through a packet update, the bit ends at 0.
- R11: A packet offered while `pkt_ready` is 0 is not accepted and has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| pkt_valid | input | 1 | Packet offered |
| pkt_data | input | 125 | Invalidation packet |
| pkt_ready | output | 1 | Block can take a packet |
| tw_en | input | 1 | Test write strobe |
| tw_icache | input | 1 | Test write target: 1 = instruction array |
| tw_set | input | 7 | Test write set |
| tw_way | input | 2 | Test write way |
| tw_val | input | 1 | Test write value |
| rd_set | input | 7 | Read port set |
| rd_dval | output | 4 | Data-cache valid bits of rd_set, one per way |
| rd_ival | output | 4 | Instruction-cache valid bits of rd_set, one per way |

## Verification
Two functions can act on the same edge: the packet update and a test write. When they target one valid bit, the invalidation has to win. The bench provokes this by driving a test write in the single busy cycle after an accept. In directed cases the write aims at the exact bit the packet clears, and at an unrelated bit. Random cases aim at random bits. The outcome is judged with a full read-port sweep of both arrays against a bench model that applies the write first and the invalidation after it.

// File: rtl/inv_pkg.sv
package inv_pkg;
  localparam int NCORE     = 8;
  localparam int CORE_W    = $clog2(NCORE);
  localparam int WAYS      = 4;
  localparam int WAY_W     = $clog2(WAYS);
  localparam int SETS      = 128;
  localparam int SET_W     = $clog2(SETS);
  localparam int NQ        = 4;
  localparam int NH        = 2;
  localparam int VEC_W     = 112;
  localparam int PKT_W     = 125;
  localparam int PA_LSB    = 112;
  localparam int PA_W      = 6;
  localparam int CPU_LSB   = 118;
  localparam int QTR_LSB   = 121;
  localparam int DALL_BIT  = 123;
  localparam int IALL_BIT  = 124;
  localparam int WIDE_W    = 4;
  localparam int NARROW_W  = 3;

  function automatic int group_base(input int q);
    case (q)
      0: return 0;
      1: return 32;
      2: return 56;
      default: return 88;
    endcase
  endfunction

  function automatic logic [WIDE_W-1:0] pick_wide(input logic [VEC_W-1:0] v,
                                                  input int q, input int core);
    return v[group_base(q) + WIDE_W*core +: WIDE_W];
  endfunction

  function automatic logic [NARROW_W-1:0] pick_narrow(input logic [VEC_W-1:0] v,
                                                      input int q, input int core);
    return v[group_base(q) + NARROW_W*core +: NARROW_W];
  endfunction

  function automatic logic [WAYS-1:0] way_onehot(input logic [WAY_W-1:0] w);
    return WAYS'(1) << w;
  endfunction

  function automatic logic [WAYS-1:0] wide_dmask(input logic [WIDE_W-1:0] c);
    return c[0] ? way_onehot(c[3:2]) : '0;
  endfunction

  function automatic logic [WAYS-1:0] wide_imask(input logic [WIDE_W-1:0] c);
    return (c[1:0] == 2'b10) ? way_onehot(c[3:2]) : '0;
  endfunction

  function automatic logic [WAYS-1:0] narrow_dmask(input logic [NARROW_W-1:0] c);
    return c[0] ? way_onehot(c[2:1]) : '0;
  endfunction

  function automatic logic [SET_W-1:0] dset_of(input logic [PA_W-1:0] pa, input logic [1:0] q);
    return {pa[PA_W-2:0], q};
  endfunction

  function automatic logic [SET_W-1:0] iset_of(input logic [PA_W-1:0] pa, input logic h);
    return {pa, h};
  endfunction
endpackage

// File: rtl/inv_field_decode.sv
module inv_field_decode
  import inv_pkg::*;
#(
  parameter int CORE_ID = 0
) (
  input  logic [PKT_W-1:0]      pkt,
  output logic [NQ*SET_W-1:0]   d_set_flat,
  output logic [NQ*WAYS-1:0]    d_mask_flat,
  output logic [NH*SET_W-1:0]   i_set_flat,
  output logic [NH*WAYS-1:0]    i_mask_flat,
  output logic                  dall_hit,
  output logic                  iall_hit
);
  logic [VEC_W-1:0] vec;
  logic [PA_W-1:0]  pa_hi;
  logic [1:0]       qtr;
  logic             id_match;

  assign vec      = pkt[VEC_W-1:0];
  assign pa_hi    = pkt[PA_LSB +: PA_W];
  assign qtr      = pkt[QTR_LSB +: 2];
  assign id_match = (pkt[CPU_LSB +: CORE_W] == CORE_W'(CORE_ID));
  assign dall_hit = id_match & pkt[DALL_BIT];
  assign iall_hit = id_match & pkt[IALL_BIT];

  for (genvar q = 0; q < NQ; q++) begin : g_qtr
    logic [WAYS-1:0] field_dmask;
    logic            all_here;
    if (q % 2 == 0) begin : g_wide
      logic [WIDE_W-1:0] code;
      logic [WAYS-1:0]   imask;
      logic              iall_here;
      assign code        = pick_wide(vec, q, CORE_ID);
      assign field_dmask = wide_dmask(code);
      assign imask       = wide_imask(code);
      assign iall_here   = iall_hit & (qtr[1] == 1'(q / 2));
      assign i_set_flat[(q/2)*SET_W +: SET_W] = iset_of(pa_hi, 1'(q / 2));
      assign i_mask_flat[(q/2)*WAYS +: WAYS]  = imask | {WAYS{iall_here}};
    end else begin : g_narrow
      logic [NARROW_W-1:0] code;
      assign code        = pick_narrow(vec, q, CORE_ID);
      assign field_dmask = narrow_dmask(code);
    end
    assign all_here = dall_hit & (qtr == 2'(q));
    assign d_set_flat[q*SET_W +: SET_W] = dset_of(pa_hi, 2'(q));
    assign d_mask_flat[q*WAYS +: WAYS]  = field_dmask | {WAYS{all_here}};
  end
endmodule

// File: rtl/inv_valid_array.sv
module inv_valid_array
  import inv_pkg::*;
#(
  parameter int NPORT = 4
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   apply,
  input  logic [NPORT*SET_W-1:0] clr_set,
  input  logic [NPORT*WAYS-1:0]  clr_mask,
  input  logic                   tw_en,
  input  logic [SET_W-1:0]       tw_set,
  input  logic [WAY_W-1:0]       tw_way,
  input  logic                   tw_val,
  input  logic [SET_W-1:0]       rd_set,
  output logic [WAYS-1:0]        rd_val,
  output logic [SETS*WAYS-1:0]   all_val
);
  localparam int NBITS = SETS * WAYS;
  logic [NBITS-1:0] vld_q, vld_d;

  always_comb begin
    vld_d = vld_q;
    if (tw_en) vld_d[int'(tw_set)*WAYS + int'(tw_way)] = tw_val;
    if (apply) begin
      for (int p = 0; p < NPORT; p++) begin
        for (int w = 0; w < WAYS; w++) begin
          if (clr_mask[p*WAYS + w])
            vld_d[int'(clr_set[p*SET_W +: SET_W])*WAYS + w] = 1'b0;
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) vld_q <= '1;
    else        vld_q <= vld_d;
  end

  assign rd_val  = vld_q[int'(rd_set)*WAYS +: WAYS];
  assign all_val = vld_q;
endmodule

// File: rtl/inv_vec_decoder.sv
module inv_vec_decoder
  import inv_pkg::*;
#(
  parameter int CORE_ID = 5
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             pkt_valid,
  input  logic [124:0]     pkt_data,
  output logic             pkt_ready,
  input  logic             tw_en,
  input  logic             tw_icache,
  input  logic [6:0]       tw_set,
  input  logic [1:0]       tw_way,
  input  logic             tw_val,
  input  logic [6:0]       rd_set,
  output logic [3:0]       rd_dval,
  output logic [3:0]       rd_ival
);
  logic               busy;
  logic               accept;
  logic               commit;
  logic [PKT_W-1:0]   pkt_q;
  logic [NQ*SET_W-1:0] d_set_flat;
  logic [NQ*WAYS-1:0]  d_mask_flat;
  logic [NH*SET_W-1:0] i_set_flat;
  logic [NH*WAYS-1:0]  i_mask_flat;
  logic               dall_hit, iall_hit;
  logic [SETS*WAYS-1:0] dv_all, iv_all;

  assign pkt_ready = ~busy;
  assign accept    = pkt_valid & ~busy;
  assign commit    = busy;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy  <= 1'b0;
      pkt_q <= '0;
    end else begin
      busy <= accept;
      if (accept) pkt_q <= pkt_data;
    end
  end

  inv_field_decode #(.CORE_ID(CORE_ID)) u_dec (
    .pkt         (pkt_q),
    .d_set_flat  (d_set_flat),
    .d_mask_flat (d_mask_flat),
    .i_set_flat  (i_set_flat),
    .i_mask_flat (i_mask_flat),
    .dall_hit    (dall_hit),
    .iall_hit    (iall_hit)
  );

  inv_valid_array #(.NPORT(NQ)) u_darr (
    .clk(clk), .rst_n(rst_n), .apply(commit),
    .clr_set(d_set_flat), .clr_mask(d_mask_flat),
    .tw_en(tw_en & ~tw_icache), .tw_set(tw_set), .tw_way(tw_way), .tw_val(tw_val),
    .rd_set(rd_set), .rd_val(rd_dval), .all_val(dv_all)
  );

  inv_valid_array #(.NPORT(NH)) u_iarr (
    .clk(clk), .rst_n(rst_n), .apply(commit),
    .clr_set(i_set_flat), .clr_mask(i_mask_flat),
    .tw_en(tw_en & tw_icache), .tw_set(tw_set), .tw_way(tw_way), .tw_val(tw_val),
    .rd_set(rd_set), .rd_val(rd_ival), .all_val(iv_all)
  );
endmodule

// File: rtl/inv_vec_checker.sv
module inv_vec_checker
  import inv_pkg::*;
(
  input logic                  clk,
  input logic                  rst_n,
  input logic                  pkt_valid,
  input logic                  pkt_ready,
  input logic                  commit,
  input logic [PKT_W-1:0]      pkt_q,
  input logic                  tw_en,
  input logic                  tw_icache,
  input logic [SET_W-1:0]      tw_set,
  input logic [WAY_W-1:0]      tw_way,
  input logic                  tw_val,
  input logic [NQ*SET_W-1:0]   d_set_flat,
  input logic [NQ*WAYS-1:0]    d_mask_flat,
  input logic [NH*SET_W-1:0]   i_set_flat,
  input logic [NH*WAYS-1:0]    i_mask_flat,
  input logic [SETS*WAYS-1:0]  dv_all,
  input logic [SETS*WAYS-1:0]  iv_all
);
  assert_reset_full_R1: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> (&dv_all && &iv_all && pkt_ready));

  assert_ready_drop_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (pkt_valid && pkt_ready) |=> !pkt_ready);

  assert_ready_back_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !pkt_ready |=> pkt_ready);

  assert_hold_busy_R11: assert property (@(posedge clk) disable iff (!rst_n)
    !pkt_ready |=> $stable(pkt_q));

  for (genvar q = 0; q < NQ; q++) begin : g_dq
    assert_dclear_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (commit && |d_mask_flat[q*WAYS +: WAYS]) |=>
      ((dv_all[int'(d_set_flat[q*SET_W +: SET_W])*WAYS +: WAYS] &
        d_mask_flat[q*WAYS +: WAYS]) == '0));
  end

  for (genvar h = 0; h < NH; h++) begin : g_ih
    assert_iclear_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (commit && |i_mask_flat[h*WAYS +: WAYS]) |=>
      ((iv_all[int'(i_set_flat[h*SET_W +: SET_W])*WAYS +: WAYS] &
        i_mask_flat[h*WAYS +: WAYS]) == '0));
  end

  assert_twrite_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (tw_en && !commit) |=>
    ((($past(tw_icache) ? iv_all : dv_all) >> (int'($past(tw_set))*WAYS + int'($past(tw_way)))) & 1)
      == ($past(tw_val) ? 1 : 0));
endmodule

bind inv_vec_decoder inv_vec_checker u_chk (
  .clk(clk), .rst_n(rst_n), .pkt_valid(pkt_valid), .pkt_ready(pkt_ready),
  .commit(commit), .pkt_q(pkt_q), .tw_en(tw_en), .tw_icache(tw_icache),
  .tw_set(tw_set), .tw_way(tw_way), .tw_val(tw_val),
  .d_set_flat(d_set_flat), .d_mask_flat(d_mask_flat),
  .i_set_flat(i_set_flat), .i_mask_flat(i_mask_flat),
  .dv_all(dv_all), .iv_all(iv_all)
);

// File: tb/sim_inv_vec_decoder.sv
`timescale 1ns/1ps
module sim_inv_vec_decoder;
  localparam int CORE = 5;

  logic         clk = 0;
  logic         rst_n = 0;
  logic         pkt_valid = 0;
  logic [124:0] pkt_data = '0;
  logic         pkt_ready;
  logic         tw_en = 0, tw_icache = 0, tw_val = 0;
  logic [6:0]   tw_set = '0, rd_set = '0;
  logic [1:0]   tw_way = '0;
  logic [3:0]   rd_dval, rd_ival;

  int checks = 0, errors = 0;
  bit done = 0;
  bit dm [128][4];
  bit im [128][4];

  always #10 clk = ~clk;

  inv_vec_decoder #(.CORE_ID(CORE)) u0 (
    .clk(clk), .rst_n(rst_n), .pkt_valid(pkt_valid), .pkt_data(pkt_data),
    .pkt_ready(pkt_ready), .tw_en(tw_en), .tw_icache(tw_icache), .tw_set(tw_set),
    .tw_way(tw_way), .tw_val(tw_val), .rd_set(rd_set), .rd_dval(rd_dval), .rd_ival(rd_ival)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp, input string what);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  function automatic logic [124:0] put(input logic [124:0] p, input int pos, input int w, input int val);
    for (int i = 0; i < w; i++) p[pos+i] = 1'((val >> i) & 1);
    return p;
  endfunction

  // Start of core CORE's field in group g, counted from the layout rules.
  function automatic int fpos(input int g, input int core);
    int starts [4] = '{0, 32, 56, 88};
    return starts[g] + ((g % 2 == 0) ? 4 : 3) * core;
  endfunction

  function automatic logic [124:0] addr(input logic [124:0] p, input int pa_hi, input int cpu, input int qtr);
    p = put(p, 112, 6, pa_hi);
    p = put(p, 118, 3, cpu);
    p = put(p, 121, 2, qtr);
    return p;
  endfunction

  task automatic model_reset();
    for (int s = 0; s < 128; s++) for (int w = 0; w < 4; w++) begin dm[s][w] = 1; im[s][w] = 1; end
  endtask

  task automatic model_pkt(input logic [124:0] p);
    int pa = int'(p[117:112]);
    for (int g = 0; g < 4; g++) begin
      int code = 0;
      for (int i = 0; i < ((g % 2 == 0) ? 4 : 3); i++) code += int'(p[fpos(g, CORE)+i]) << i;
      if (g % 2 == 0) begin
        if (code % 2 == 1)            dm[(pa % 32) * 4 + g][code / 4] = 0;
        else if ((code / 2) % 2 == 1) im[pa * 2 + g / 2][code / 4] = 0;
      end else if (code % 2 == 1) begin
        dm[(pa % 32) * 4 + g][(code / 2) % 4] = 0;
      end
    end
    if (int'(p[120:118]) == CORE) begin
      if (p[123]) for (int w = 0; w < 4; w++) dm[(pa % 32) * 4 + int'(p[122:121])][w] = 0;
      if (p[124]) for (int w = 0; w < 4; w++) im[pa * 2 + int'(p[122])][w] = 0;
    end
  endtask

  task automatic sweep(input string req);
    for (int s = 0; s < 128; s++) begin
      logic [3:0] ed, ei;
      rd_set = 7'(s);
      #1;
      for (int w = 0; w < 4; w++) begin ed[w] = dm[s][w]; ei[w] = im[s][w]; end
      check(req, {20'd0, 1'b0, 7'(s), rd_dval}, {20'd0, 1'b0, 7'(s), ed}, "dcache valid (set in bits 10:4)");
      check(req, {20'd0, 1'b0, 7'(s), rd_ival}, {20'd0, 1'b0, 7'(s), ei}, "icache valid (set in bits 10:4)");
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 0;
    @(negedge clk);
    rst_n = 1;
    model_reset();
  endtask

  task automatic twrite(input bit ic, input int s, input int w, input bit v);
    @(negedge clk);
    tw_en = 1; tw_icache = ic; tw_set = 7'(s); tw_way = 2'(w); tw_val = v;
    @(negedge clk);
    tw_en = 0;
    if (ic) im[s][w] = v; else dm[s][w] = v;
  endtask

  // Offer p; optional test write and optional rogue packet during the busy cycle.
  task automatic send(input logic [124:0] p, input bit col, input bit ic, input int s, input int w,
                      input bit v, input bit rogue, input logic [124:0] rp);
    @(negedge clk);
    while (!pkt_ready) @(negedge clk);
    pkt_valid = 1; pkt_data = p;
    @(negedge clk);
    check("R2", {31'd0, pkt_ready}, 32'd0, "ready in busy cycle");
    pkt_valid = rogue; pkt_data = rp;
    if (col) begin tw_en = 1; tw_icache = ic; tw_set = 7'(s); tw_way = 2'(w); tw_val = v; end
    @(negedge clk);
    pkt_valid = 0; tw_en = 0;
    check("R2", {31'd0, pkt_ready}, 32'd1, "ready after commit");
    if (col) begin if (ic) im[s][w] = v; else dm[s][w] = v; end
    model_pkt(p);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [124:0] p, z;
    void'($urandom(32'd2718));
    z = '0;
    model_reset();
    repeat (2) @(negedge clk);
    #1;
    check("R1", {31'd0, pkt_ready}, 32'd1, "ready while in reset");
    rst_n = 1;
    @(negedge clk);
    check("R1", {31'd0, pkt_ready}, 32'd1, "ready after reset");
    sweep("R1");

    // R4: quarter 0 data way 2 (code 1001), quarter 2 instruction way 1 (code 0110)
    p = addr(z, 6'h2b, 0, 0);
    p = put(p, fpos(0, CORE), 4, 4'b1001);
    p = put(p, fpos(2, CORE), 4, 4'b0110);
    send(p, 0, 0, 0, 0, 0, 0, z);
    sweep("R4");

    // R5 and R3: quarters 1 and 3, data ways 3 and 0
    p = addr(z, 6'h11, 2, 0);
    p = put(p, fpos(1, CORE), 3, 3'b111);
    p = put(p, fpos(3, CORE), 3, 3'b001);
    send(p, 0, 0, 0, 0, 0, 0, z);
    sweep("R5");

    // R9: all quarters plus both clear-all bits in one packet
    do_reset();
    p = addr(z, 6'h3f, CORE, 2);
    p = put(p, fpos(0, CORE), 4, 4'b0011);
    p = put(p, fpos(1, CORE), 3, 3'b011);
    p = put(p, fpos(2, CORE), 4, 4'b1110);
    p = put(p, fpos(3, CORE), 3, 3'b101);
    p[123] = 1; p[124] = 1;
    send(p, 0, 0, 0, 0, 0, 0, z);
    sweep("R9");

    // R8: only neighbouring cores' fields set
    do_reset();
    p = addr(z, 6'h05, 4, 1);
    for (int g = 0; g < 4; g++) begin
      p = put(p, fpos(g, CORE - 1), (g % 2 == 0) ? 4 : 3, 5);
      p = put(p, fpos(g, CORE + 1), (g % 2 == 0) ? 4 : 3, 3);
    end
    send(p, 0, 0, 0, 0, 0, 0, z);
    sweep("R8");

    // R6: clear-all with matching cpu id
    p = addr(z, 6'h1a, CORE, 3);
    p[123] = 1; p[124] = 1;
    send(p, 0, 0, 0, 0, 0, 0, z);
    sweep("R6");

    // R7: clear-all with other cpu id
    do_reset();
    p = addr(z, 6'h1a, CORE ^ 1, 3);
    p[123] = 1; p[124] = 1;
    send(p, 0, 0, 0, 0, 0, 0, z);
    sweep("R7");

    // R10: test write sets back a bit the same packet clears (quarter 0 data way 2, set 4*(0x0c)+0)
    p = addr(z, 6'h0c, 0, 0);
    p = put(p, fpos(0, CORE), 4, 4'b1001);
    send(p, 1, 0, 48, 2, 1, 0, z);
    sweep("R10");
    // R10: test write to an unrelated bit during commit
    send(p, 1, 1, 77, 3, 0, 0, z);
    sweep("R10");
    twrite(0, 48, 2, 1);
    twrite(1, 100, 0, 0);
    sweep("R10");

    // R11: rogue packet offered in the busy cycle
    do_reset();
    p = addr(z, 6'h01, 0, 0);
    p = put(p, fpos(0, CORE), 4, 4'b0101);
    begin
      logic [124:0] rp;
      rp = addr(z, 6'h30, CORE, 1);
      rp[123] = 1; rp[124] = 1;
      rp = put(rp, fpos(1, CORE), 3, 3'b111);
      send(p, 0, 0, 0, 0, 0, 1, rp);
    end
    @(negedge clk);
    check("R11", {31'd0, pkt_ready}, 32'd1, "no second accept");
    sweep("R11");

    // Random packets, collisions and refills
    do_reset();
    for (int it = 0; it < 120; it++) begin
      bit col;
      p = {29'($urandom), $urandom, $urandom, $urandom};
      if (it % 3 == 0) p[120:118] = 3'(CORE);
      col = ($urandom % 2) == 1;
      send(p, col, 1'($urandom), int'($urandom % 128), int'($urandom % 4), 1'($urandom), 0, z);
      if (it % 10 == 9) sweep("R9");
      for (int k = 0; k < 3; k++) twrite(1'($urandom), int'($urandom % 128), int'($urandom % 4), 1);
    end
    sweep("R4");

    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule